// File: doc/BRIEF.md
# Chained Event Counter Pair

Two 32-bit event counters sit behind a small register port. Each counter picks what it counts through an event-type code: the hardware tick input, a software-increment request, or (on the odd counter only) the carry out of its even neighbour. When the odd counter takes the carry, the pair behaves as one 64-bit counter. In that mode the low half's wrap is not flagged, and only a wrap of the high half reaches the overflow status.

Counting is gated by two things: a per-counter bit in an enable mask, and a global enable input. Software sets and clears mask bits through separate set and clear registers. It presets counters by writing them directly and requests software increments with a bitmask write. It clears overflow flags by writing ones. A read port returns any register combinationally.

Register addresses (3 bits): 0 counter 0, 1 counter 1, 2 event type 0, 3 event type 1, 4 enable set, 5 enable clear (both read back the mask), 6 overflow status, 7 software increment (reads 0). Event codes: 0x11 tick, 0x00 software increment, 0x1E chain.

Top module: `evt_pair_counter`

## Requirements
- R1: After reset, both counters, both event types, the enable mask and the overflow status read 0.
- R2: A counter with event type 0x11 advances by one on each clock with `tick` high, but only when its mask bit and `global_en` are both set.
- R3: Counters are 32 bits and wrap from 0xFFFFFFFF to 0 (100 increments from 0xFFFFFFF0 give 84). An unchained wrap of counter 0 sets overflow bit 0.
- R4: Writing a mask to address 7 advances by one each enabled counter of type 0x00 whose mask bit is 1. The write has no effect while `global_en` is 0.
- R5: With event type 1 at 0x1E, counter 1 advances by one on each wrap of counter 0, and overflow bit 0 stays clear.
- R6: A wrap of a chained counter 1 from 0xFFFFFFFF to 0 sets overflow bit 1, so the status reads 0x2.
- R7: A chained counter 1 ignores its software-increment bit; writing 0x3 to address 7 moves only counter 0.
- R8: Writing 1s to address 4 sets mask bits, writing 1s to address 5 clears them, and 0s leave bits unchanged. A cleared bit stops its counter.
- R9: Writing 1 to a bit of address 6 clears that overflow flag; writing 0 leaves it set.
- R10: Counter 0 given event type 0x1E counts neither ticks nor software increments.
- R11: Writing address 0 or 1 presets that counter to the written value on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| global_en | input | 1 | Global count enable |
| tick | input | 1 | Hardware event, one count per high clock |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | 32 | Write data |
| rd_addr | input | 3 | Read address |
| rd_data | output | 32 | Read data, combinational |

## Verification
The hardest state to reach from the ports is a wrap of the high half of a chained pair. It needs counter 1 preset to all ones, counter 0 preset just below its wrap, and enough counter 0 events to carry. Each scenario presets both halves through the register port, then drives a known number of ticks or software-increment writes. The bench checks the exact wrap arithmetic and the overflow pattern, including that the low-half flag stays clear while counter 1 rolls to zero.

// File: rtl/evt_pair_pkg.sv
package evt_pair_pkg;
  localparam int EVT_W = 8;
  localparam logic [EVT_W-1:0] EVT_SWINC = 8'h00;
  localparam logic [EVT_W-1:0] EVT_TICK  = 8'h11;
  localparam logic [EVT_W-1:0] EVT_CHAIN = 8'h1E;

  typedef enum logic [2:0] {
    A_CNT0  = 3'd0,
    A_CNT1  = 3'd1,
    A_TYPE0 = 3'd2,
    A_TYPE1 = 3'd3,
    A_ENSET = 3'd4,
    A_ENCLR = 3'd5,
    A_OVF   = 3'd6,
    A_SWINC = 3'd7
  } reg_addr_e;

  // One event hit for a counter from its type and the two direct sources.
  function automatic logic evt_hit(input logic [EVT_W-1:0] typ,
                                   input logic tk, input logic sw);
    return ((typ == EVT_TICK) && tk) || ((typ == EVT_SWINC) && sw);
  endfunction
endpackage

// File: rtl/evt_pair_step.sv
module evt_pair_step
  import evt_pair_pkg::*;
#(
  parameter int NCTR = 2
) (
  input  logic [EVT_W-1:0] typ [NCTR],
  input  logic [NCTR-1:0]  en_mask,
  input  logic             global_en,
  input  logic             tick,
  input  logic [NCTR-1:0]  sw_mask,
  input  logic             carry0,
  output logic [NCTR-1:0]  step,
  output logic             chained
);
  assign chained = (typ[1] == EVT_CHAIN);

  always_comb begin
    step[0] = en_mask[0] && global_en && evt_hit(typ[0], tick, sw_mask[0]);
    if (chained)
      step[1] = en_mask[1] && global_en && carry0;
    else
      step[1] = en_mask[1] && global_en && evt_hit(typ[1], tick, sw_mask[1]);
  end
endmodule

// File: rtl/evt_pair_cnt.sv
module evt_pair_cnt #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             step,
  output logic [CNT_W-1:0] value,
  output logic             wrap
);
  // Sum with carry out; carry marks the roll from all ones to zero.
  function automatic logic [CNT_W:0] bump(input logic [CNT_W-1:0] v, input logic s);
    return {1'b0, v} + {{CNT_W{1'b0}}, s};
  endfunction

  logic [CNT_W:0] sum;
  assign sum  = bump(value, step);
  assign wrap = !load && sum[CNT_W];

  always_ff @(posedge clk) begin
    if (!rst_n)    value <= '0;
    else if (load) value <= load_val;
    else           value <= sum[CNT_W-1:0];
  end
endmodule

// File: rtl/evt_pair_counter.sv
module evt_pair_counter
  import evt_pair_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int AW    = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             global_en,
  input  logic             tick,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  input  logic [AW-1:0]    rd_addr,
  output logic [CNT_W-1:0] rd_data
);
  localparam int NCTR = 2;

  logic [EVT_W-1:0] typ_q [NCTR];
  logic [NCTR-1:0]  en_q, ovf_q, sw_mask, step, wrap, load;
  logic [CNT_W-1:0] cnt [NCTR];
  logic             chained;
  logic             wr_ovf;
  logic [CNT_W-1:0] cnt0_w, cnt1_w;

  assign sw_mask = (wr_en && wr_addr == AW'(A_SWINC)) ? wr_data[NCTR-1:0] : '0;
  assign wr_ovf  = wr_en && wr_addr == AW'(A_OVF);

  evt_pair_step #(.NCTR(NCTR)) i_step (
    .typ(typ_q), .en_mask(en_q), .global_en(global_en), .tick(tick),
    .sw_mask(sw_mask), .carry0(wrap[0]), .step(step), .chained(chained)
  );

  for (genvar i = 0; i < NCTR; i++) begin : g_cnt
    assign load[i] = wr_en && wr_addr == AW'(i);
    evt_pair_cnt #(.CNT_W(CNT_W)) i_cnt (
      .clk(clk), .rst_n(rst_n), .load(load[i]), .load_val(wr_data),
      .step(step[i]), .value(cnt[i]), .wrap(wrap[i])
    );
    always_ff @(posedge clk) begin
      if (!rst_n) typ_q[i] <= '0;
      else if (wr_en && wr_addr == AW'(A_TYPE0 + i)) typ_q[i] <= wr_data[EVT_W-1:0];
    end
  end

  assign cnt0_w = cnt[0];
  assign cnt1_w = cnt[1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q  <= '0;
      ovf_q <= '0;
    end else begin
      if (wr_en && wr_addr == AW'(A_ENSET)) en_q <= en_q | wr_data[NCTR-1:0];
      else if (wr_en && wr_addr == AW'(A_ENCLR)) en_q <= en_q & ~wr_data[NCTR-1:0];
      // A new wrap wins over a clear written in the same cycle.
      ovf_q <= (ovf_q & ~(wr_ovf ? wr_data[NCTR-1:0] : '0))
             | {wrap[1], wrap[0] && !chained};
    end
  end

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      AW'(A_CNT0):  rd_data = cnt[0];
      AW'(A_CNT1):  rd_data = cnt[1];
      AW'(A_TYPE0): rd_data = CNT_W'(typ_q[0]);
      AW'(A_TYPE1): rd_data = CNT_W'(typ_q[1]);
      AW'(A_ENSET),
      AW'(A_ENCLR): rd_data = CNT_W'(en_q);
      AW'(A_OVF):   rd_data = CNT_W'(ovf_q);
      default:      rd_data = '0;
    endcase
  end
endmodule

// File: rtl/evt_pair_checker.sv
module evt_pair_checker
  import evt_pair_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int AW    = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             global_en,
  input logic             wr_en,
  input logic [AW-1:0]    wr_addr,
  input logic [CNT_W-1:0] wr_data,
  input logic [CNT_W-1:0] cnt0,
  input logic [CNT_W-1:0] cnt1,
  input logic [1:0]       step,
  input logic [1:0]       wrap,
  input logic [1:0]       ovf,
  input logic             chained,
  input logic [EVT_W-1:0] typ0
);
  assert_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!global_en && !wr_en) |=> ($stable(cnt0) && $stable(cnt1)));

  assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (chained && wrap[0] && !ovf[0]) |=> !ovf[0]);

  assert_high_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wrap[1] |=> ovf[1]);

  assert_carry_only_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (chained && step[1]) |-> wrap[0]);

  assert_even_chain_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (typ0 == EVT_CHAIN) |-> !step[0]);

  assert_preset_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == AW'(0)) |=> (cnt0 == $past(wr_data)));
endmodule

bind evt_pair_counter evt_pair_checker #(.CNT_W(CNT_W), .AW(AW)) i_chk (
  .clk(clk), .rst_n(rst_n), .global_en(global_en), .wr_en(wr_en),
  .wr_addr(wr_addr), .wr_data(wr_data), .cnt0(cnt0_w), .cnt1(cnt1_w),
  .step(step), .wrap(wrap), .ovf(ovf_q), .chained(chained), .typ0(typ_q[0])
);

// File: tb/test_evt_pair_counter.sv
module test_evt_pair_counter;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        global_en = 0;
  logic        tick = 0;
  logic        wr_en = 0;
  logic [2:0]  wr_addr = 0;
  logic [31:0] wr_data = 0;
  logic [2:0]  rd_addr = 0;
  logic [31:0] rd_data;
  int errs = 0;
  int checks = 0;
  bit done = 0;

  always #2 clk = ~clk;

  evt_pair_counter i_evt_pair_counter (
    .clk(clk), .rst_n(rst_n), .global_en(global_en), .tick(tick),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data)
  );

  task automatic do_reset();
    @(negedge clk); rst_n = 0; global_en = 0; tick = 0; wr_en = 0;
    @(negedge clk); @(negedge clk); rst_n = 1;
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic chk(input string req, input logic [2:0] a, input logic [31:0] exp);
    rd_addr = a; #1;
    checks++;
    if (rd_data !== exp) begin
      errs++;
      $display("FAIL %s addr=%0d actual=%h expected=%h", req, a, rd_data, exp);
    end
  endtask

  task automatic ticks(input int n);
    @(negedge clk); tick = 1;
    repeat (n) @(negedge clk);
    tick = 0;
  endtask

  task automatic swinc(input int n, input logic [31:0] m);
    for (int i = 0; i < n; i++) wr(3'd7, m);
  endtask

  task automatic t_reset();
    do_reset();
    for (int a = 0; a < 8; a++) chk("R1", 3'(a), 32'h0);
  endtask

  task automatic t_tick_enable();
    do_reset();
    wr(3'd2, 32'h11); wr(3'd4, 32'h1);
    chk("R8", 3'd4, 32'h1);
    ticks(5); chk("R2", 3'd0, 32'd0);
    global_en = 1;
    ticks(5); chk("R2", 3'd0, 32'd5);
    chk("R2", 3'd1, 32'd0);
    wr(3'd4, 32'h2); chk("R8", 3'd5, 32'h3);
    wr(3'd5, 32'h1); chk("R8", 3'd4, 32'h2);
    ticks(3); chk("R8", 3'd0, 32'd5);
  endtask

  task automatic t_swinc_wrap();
    do_reset();
    wr(3'd0, 32'hFFFF_FFF0); wr(3'd4, 32'h3);
    swinc(100, 32'h3);
    chk("R4", 3'd0, 32'hFFFF_FFF0);
    global_en = 1;
    swinc(100, 32'h3);
    chk("R3", 3'd0, 32'd84);
    chk("R4", 3'd1, 32'd100);
    chk("R3", 3'd6, 32'h1);
    wr(3'd6, 32'h0); chk("R9", 3'd6, 32'h1);
    wr(3'd6, 32'h1); chk("R9", 3'd6, 32'h0);
    wr(3'd1, 32'h1234_5678); chk("R11", 3'd1, 32'h1234_5678);
  endtask

  task automatic t_chain_swinc();
    do_reset(); global_en = 1;
    wr(3'd3, 32'h1E); wr(3'd0, 32'hFFFF_FFF0); wr(3'd4, 32'h3);
    swinc(100, 32'h3);
    chk("R7", 3'd0, 32'd84);
    chk("R7", 3'd1, 32'd1);
    chk("R5", 3'd6, 32'h0);
  endtask

  task automatic t_chain_overflow();
    do_reset(); global_en = 1;
    wr(3'd3, 32'h1E); wr(3'd0, 32'hFFFF_FFF0); wr(3'd1, 32'hFFFF_FFFF);
    wr(3'd4, 32'h3);
    swinc(100, 32'h3);
    chk("R6", 3'd1, 32'd0);
    chk("R6", 3'd6, 32'h2);
    chk("R6", 3'd0, 32'd84);
  endtask

  task automatic t_chain_tick();
    do_reset(); global_en = 1;
    wr(3'd2, 32'h11); wr(3'd3, 32'h1E);
    wr(3'd0, 32'hFFFF_FFF0); wr(3'd4, 32'h3);
    ticks(22);
    chk("R5", 3'd0, 32'd6);
    chk("R5", 3'd1, 32'd1);
    chk("R5", 3'd6, 32'h0);
  endtask

  task automatic t_even_chain();
    do_reset(); global_en = 1;
    wr(3'd2, 32'h1E); wr(3'd4, 32'h1); wr(3'd0, 32'd7);
    chk("R11", 3'd0, 32'd7);
    ticks(4); swinc(3, 32'h1);
    chk("R10", 3'd0, 32'd7);
  endtask

  initial begin
    t_reset();
    t_tick_enable();
    t_swinc_wrap();
    t_chain_swinc();
    t_chain_overflow();
    t_chain_tick();
    t_even_chain();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        errs++; checks++;
        $display("FAIL watchdog actual=timeout expected=completion");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule